// File: doc/BRIEF.md
# Reset qualifier and power-mode clock controller

This block generates the state timing for a small 8-bit processor core and controls its clocks. The core runs on a machine cycle of six states with two phases each, one oscillator clock per phase, so a machine cycle takes twelve oscillator clocks. The block also produces a divide-by-two state clock, so the duty cycle of the incoming oscillator does not reach the logic. The external reset pin is active high. It is synchronised and then sampled once per machine cycle, at a single fixed state and phase. An internal reset is raised only after the pin has been seen high at two samples in a row, so short glitches cause no reset.

The block holds the power-control register. The core writes it, and the register keeps its reset value here. Bit 0 requests idle: the processor clock enable drops and the peripheral clock enable stays on until an interrupt is pending or a reset occurs. Bit 1 requests power-down: both enables drop, the timing counter freezes, and only a qualified reset pin can wake the block. Both enables are registered and change only at a machine-cycle boundary, so the downstream clock gates never see a shortened pulse.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: While the timing counter runs, `state_clk_o` inverts on every oscillator clock. Its reset value is 0.
- R2: `phase_o` alternates 0,1 on every oscillator clock. `state_o` steps through 0..5, advancing when the phase is 1, and wraps from 5 to 0. `rst_ni` clears both to 0. The machine-cycle boundary is the edge that leaves state 5, phase 1.
- R3: The synchronised reset pin is sampled only on the edge that leaves state 4, phase 1. `int_rst_o` changes only on that edge, so a pin pulse that misses the sample point has no effect.
- R4: `int_rst_o` is 1 after `rst_ni`. It goes to 1 once two consecutive samples are high, and a single high sample leaves it at 0. It returns to 0 at the first low sample.
- R5: The power-control register reads back on `pcon_o`, with bit 0 for idle and bit 1 for power-down. A write takes effect only while `cpu_clk_en_o` is 1. Otherwise it is ignored.
- R6: While `int_rst_o` is 1, the power-control register clears to 00h, except bit 4, which keeps its value.
- R7: If bit 0 is set at a boundary, `cpu_clk_en_o` becomes 0 after that boundary and `per_clk_en_o` stays 1.
- R8: Idle is left at a boundary where `irq_pend_i` is 1 or `int_rst_o` is 1. `cpu_clk_en_o` then returns to 1 and bit 0 clears.
- R9: In power-down both enables are 0 and `state_o`, `phase_o` and `state_clk_o` hold still. `irq_pend_i` has no effect.
- R10: Power-down is left only through a qualified reset. A pin pulse that covers just one sample lets the counter run until the next sample, then freezes it again with both enables still 0.
- R11: If bits 0 and 1 are both set, power-down takes priority over idle.
- R12: `cpu_clk_en_o` and `per_clk_en_o` change only at a machine-cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| irq_pend_i | input | 1 | Interrupt pending, used to leave idle |
| pcon_we_i | input | 1 | Write strobe for the power-control register |
| pcon_wdata_i | input | 8 | Write data for the power-control register |
| pcon_o | output | 8 | Power-control register contents |
| state_o | output | 3 | Current state, 0..5 |
| phase_o | output | 1 | Current phase within the state |
| state_clk_o | output | 1 | Divide-by-two state clock |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| per_clk_en_o | output | 1 | Peripheral and interrupt clock enable |
| int_rst_o | output | 1 | Qualified internal reset |

## Verification
Two functions can fall on the same machine-cycle boundary: a qualified reset and an interrupt waking the core from idle. The bench enters idle with bit 4 set, holds the pin high across two sample points, and raises the interrupt in the second of those machine cycles. Both wake causes then land on the same boundary. It checks that the core resumes with `pcon_o` reduced to bit 4 alone, and that the processor enable does not come back a cycle early. A second overlap is a single write that sets idle and power-down together. The bench checks that the peripheral enable also drops, which shows that power-down won.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pmode_e;

  localparam int unsigned IDL_BIT_DEF  = 0;
  localparam int unsigned PD_BIT_DEF   = 1;
  localparam int unsigned KEEP_BIT_DEF = 4;
endpackage

// File: rtl/pwr_timing_gen.sv
module pwr_timing_gen #(
  parameter int unsigned N_STATES  = 6,
  parameter int unsigned N_PHASES  = 2,
  parameter int unsigned SMP_STATE = 4,
  parameter int unsigned SMP_PHASE = 1,
  localparam int unsigned SW = $clog2(N_STATES),
  localparam int unsigned PW = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [SW-1:0] state_o,
  output logic [PW-1:0] phase_o,
  output logic          sclk_o,
  output logic          smp_o,
  output logic          mc_end_o
);
  localparam logic [SW-1:0] LAST_S = SW'(N_STATES - 1);
  localparam logic [PW-1:0] LAST_P = PW'(N_PHASES - 1);
  localparam logic [SW-1:0] SMP_S  = SW'(SMP_STATE);
  localparam logic [PW-1:0] SMP_P  = PW'(SMP_PHASE);

  logic [SW-1:0] state_q;
  logic [PW-1:0] phase_q;
  logic          sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      phase_q <= '0;
      sclk_q  <= 1'b0;
    end else if (run_i) begin
      sclk_q <= ~sclk_q;
      if (phase_q == LAST_P) begin
        phase_q <= '0;
        state_q <= (state_q == LAST_S) ? '0 : state_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign state_o  = state_q;
  assign phase_o  = phase_q;
  assign sclk_o   = sclk_q;
  assign smp_o    = run_i && (state_q == SMP_S) && (phase_q == SMP_P);
  assign mc_end_o = run_i && (state_q == LAST_S) && (phase_q == LAST_P);

  assert_div2_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (sclk_q != $past(sclk_q)));

  assert_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(state_q) && $stable(phase_q) && $stable(sclk_q)));
endmodule

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
  parameter int unsigned HOLD_CYC    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic smp_i,
  output logic pin_s_o,
  output logic int_rst_o
);
  localparam logic [CW-1:0] HOLD    = CW'(HOLD_CYC);
  localparam logic [CW-1:0] HOLD_M1 = CW'(HOLD_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   int_rst_q;
  logic                   pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end
  assign pin_s = sync_q[SYNC_STAGES-1];

  // one decision per machine cycle, at the fixed sample point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      int_rst_q <= 1'b1;
    end else if (smp_i) begin
      if (pin_s) begin
        if (cnt_q != HOLD) cnt_q <= cnt_q + 1'b1;
        if (cnt_q >= HOLD_M1) int_rst_q <= 1'b1;
      end else begin
        cnt_q     <= '0;
        int_rst_q <= 1'b0;
      end
    end
  end

  assign pin_s_o   = pin_s;
  assign int_rst_o = int_rst_q;

  assert_sample_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_i |=> $stable(int_rst_q));

  assert_low_sample_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && !pin_s) |=> !int_rst_q);
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_pkg::*;
#(
  parameter int unsigned PCON_W   = 8,
  parameter int unsigned IDL_BIT  = IDL_BIT_DEF,
  parameter int unsigned PD_BIT   = PD_BIT_DEF,
  parameter int unsigned KEEP_BIT = KEEP_BIT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_end_i,
  input  logic              smp_i,
  input  logic              int_rst_i,
  input  logic              wake_i,
  input  logic              irq_i,
  input  logic              we_i,
  input  logic [PCON_W-1:0] wdata_i,
  output logic [PCON_W-1:0] pcon_o,
  output logic              cpu_en_o,
  output logic              per_en_o,
  output logic              run_o
);
  localparam logic [PCON_W-1:0] KEEP_MASK = PCON_W'(1) << KEEP_BIT;
  localparam logic [PCON_W-1:0] MODE_MASK = (PCON_W'(1) << IDL_BIT) | (PCON_W'(1) << PD_BIT);

  pmode_e            mode_q, mode_nxt;
  logic [PCON_W-1:0] pcon_q;
  logic              cpu_en_q, per_en_q, wake_q;

  always_comb begin
    mode_nxt = mode_q;
    if (int_rst_i) begin
      mode_nxt = MODE_RUN;
    end else begin
      unique case (mode_q)
        MODE_RUN: begin
          if (pcon_q[PD_BIT])       mode_nxt = MODE_PDOWN;
          else if (pcon_q[IDL_BIT]) mode_nxt = MODE_IDLE;
        end
        MODE_IDLE:  if (irq_i) mode_nxt = MODE_RUN;
        MODE_PDOWN: mode_nxt = MODE_PDOWN;
        default:    mode_nxt = MODE_RUN;
      endcase
    end
  end

  // enables move only on the machine-cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RUN;
      cpu_en_q <= 1'b1;
      per_en_q <= 1'b1;
    end else if (mc_end_i) begin
      mode_q   <= mode_nxt;
      cpu_en_q <= (mode_nxt == MODE_RUN);
      per_en_q <= (mode_nxt != MODE_PDOWN);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcon_q <= '0;
    end else if (int_rst_i) begin
      pcon_q <= pcon_q & KEEP_MASK;
    end else if (mc_end_i && (mode_q != MODE_RUN) && (mode_nxt == MODE_RUN)) begin
      pcon_q <= pcon_q & ~MODE_MASK;
    end else if (we_i && cpu_en_q) begin
      pcon_q <= wdata_i;
    end
  end

  // power-down wake: run the counter while the pin is high, refreeze on a low sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  wake_q <= 1'b0;
    else if (mode_q != MODE_PDOWN) wake_q <= 1'b0;
    else if (wake_i)              wake_q <= 1'b1;
    else if (smp_i)               wake_q <= 1'b0;
  end

  assign pcon_o   = pcon_q;
  assign cpu_en_o = cpu_en_q;
  assign per_en_o = per_en_q;
  assign run_o    = (mode_q != MODE_PDOWN) || wake_q;

  assert_gate_boundary_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mc_end_i |=> ($stable(cpu_en_q) && $stable(per_en_q)));

  assert_pd_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PDOWN && !int_rst_i) |=> (mode_q == MODE_PDOWN));

  assert_keep_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_i |=> ((pcon_q & ~KEEP_MASK) == '0 && pcon_q[KEEP_BIT] == $past(pcon_q[KEEP_BIT])));

  assert_pd_priority_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_end_i && !int_rst_i && mode_q == MODE_RUN && pcon_q[PD_BIT]) |=> !per_en_q);
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import pwr_pkg::*;
#(
  parameter int unsigned N_STATES = 6,
  parameter int unsigned N_PHASES = 2,
  parameter int unsigned HOLD_CYC = 2,
  parameter int unsigned PCON_W   = 8,
  localparam int unsigned SW = $clog2(N_STATES),
  localparam int unsigned PW = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              irq_pend_i,
  input  logic              pcon_we_i,
  input  logic [PCON_W-1:0] pcon_wdata_i,
  output logic [PCON_W-1:0] pcon_o,
  output logic [SW-1:0]     state_o,
  output logic [PW-1:0]     phase_o,
  output logic              state_clk_o,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              int_rst_o
);
  logic run, smp, mc_end, pin_s, int_rst;

  pwr_timing_gen #(
    .N_STATES (N_STATES),
    .N_PHASES (N_PHASES),
    .SMP_STATE(N_STATES - 2),
    .SMP_PHASE(N_PHASES - 1)
  ) u_tgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .state_o (state_o),
    .phase_o (phase_o),
    .sclk_o  (state_clk_o),
    .smp_o   (smp),
    .mc_end_o(mc_end)
  );

  pwr_rst_qual #(
    .HOLD_CYC   (HOLD_CYC),
    .SYNC_STAGES(2)
  ) u_rqual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (rst_pin_i),
    .smp_i    (smp),
    .pin_s_o  (pin_s),
    .int_rst_o(int_rst)
  );

  pwr_seq #(
    .PCON_W(PCON_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mc_end_i (mc_end),
    .smp_i    (smp),
    .int_rst_i(int_rst),
    .wake_i   (pin_s),
    .irq_i    (irq_pend_i),
    .we_i     (pcon_we_i),
    .wdata_i  (pcon_wdata_i),
    .pcon_o   (pcon_o),
    .cpu_en_o (cpu_clk_en_o),
    .per_en_o (per_clk_en_o),
    .run_o    (run)
  );

  assign int_rst_o = int_rst;
endmodule

// File: tb/tb_pwr_rst_ctrl.sv
module tb_pwr_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {machine cycles the pin is held high, expected int_rst after the last sample}
  localparam int VEC [NVEC][2] = '{'{1, 0}, '{2, 1}, '{3, 1}, '{1, 0}, '{4, 1}};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rst_pin_i = 1'b0;
  logic       irq_pend_i = 1'b0;
  logic       pcon_we_i = 1'b0;
  logic [7:0] pcon_wdata_i = 8'h00;
  logic [7:0] pcon_o;
  logic [2:0] state_o;
  logic [0:0] phase_o;
  logic       state_clk_o, cpu_clk_en_o, per_clk_en_o, int_rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwr_rst_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_pin_i(rst_pin_i), .irq_pend_i(irq_pend_i),
    .pcon_we_i(pcon_we_i), .pcon_wdata_i(pcon_wdata_i), .pcon_o(pcon_o),
    .state_o(state_o), .phase_o(phase_o), .state_clk_o(state_clk_o),
    .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o), .int_rst_o(int_rst_o)
  );

  function automatic int cur_idx();
    return int'(state_o) * 2 + int'(phase_o);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idx(input int v);
    @(negedge clk_i);
    while (cur_idx() != v) @(negedge clk_i);
  endtask

  task automatic pcon_write(input logic [7:0] d);
    pcon_we_i = 1'b1;
    pcon_wdata_i = d;
    @(negedge clk_i);
    pcon_we_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev, snap;
    logic sc;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state
    chk(cur_idx() == 0, "R2 reset idx", cur_idx(), 0);
    chk(int_rst_o == 1'b1, "R4 reset int_rst", int_rst_o, 1);
    chk(pcon_o == 8'h00, "R6 reset pcon", pcon_o, 0);
    chk(cpu_clk_en_o && per_clk_en_o, "R12 reset enables", {cpu_clk_en_o, per_clk_en_o}, 3);
    chk(state_clk_o == 1'b0, "R1 reset state clk", state_clk_o, 0);

    // R1, R2: divide-by-two and phase sequence over 14 clocks
    prev = cur_idx();
    sc = state_clk_o;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk_i);
      chk(cur_idx() == (prev + 1) % 12, "R2 phase sequence", cur_idx(), (prev + 1) % 12);
      chk(state_clk_o == ~sc, "R1 state clk toggle", state_clk_o, ~sc);
      prev = cur_idx();
      sc = state_clk_o;
      if (cur_idx() == 9) chk(int_rst_o == 1'b1, "R3 held before sample", int_rst_o, 1);
      if (cur_idx() == 10) chk(int_rst_o == 1'b0, "R4 low sample clears", int_rst_o, 0);
    end

    // R4: table of hold lengths
    for (int v = 0; v < NVEC; v++) begin
      wait_idx(0);
      rst_pin_i = 1'b1;
      for (int k = 0; k < VEC[v][0]; k++) wait_idx(10);
      chk(int_rst_o == VEC[v][1][0], "R4 hold length", int_rst_o, VEC[v][1]);
      rst_pin_i = 1'b0;
      wait_idx(10);
      chk(int_rst_o == 1'b0, "R4 release", int_rst_o, 0);
    end

    // R3: pulses missing the sample point in two consecutive cycles
    for (int k = 0; k < 2; k++) begin
      wait_idx(0);
      rst_pin_i = 1'b1;
      wait_idx(6);
      rst_pin_i = 1'b0;
    end
    wait_idx(10);
    chk(int_rst_o == 1'b0, "R3 off-sample pulse ignored", int_rst_o, 0);

    // R5, R7, R8, R12: idle
    wait_idx(2);
    pcon_write(8'h01);
    chk(pcon_o == 8'h01, "R5 write readback", pcon_o, 8'h01);
    wait_idx(11);
    chk(cpu_clk_en_o == 1'b1, "R12 no change before boundary", cpu_clk_en_o, 1);
    wait_idx(0);
    chk(!cpu_clk_en_o && per_clk_en_o, "R7 idle gating", {cpu_clk_en_o, per_clk_en_o}, 1);
    wait_idx(2);
    pcon_write(8'h02);
    chk(pcon_o == 8'h01, "R5 write ignored in idle", pcon_o, 8'h01);
    wait_idx(0);
    chk(per_clk_en_o == 1'b1, "R5 ignored write no effect", per_clk_en_o, 1);
    wait_idx(2);
    irq_pend_i = 1'b1;
    wait_idx(0);
    irq_pend_i = 1'b0;
    chk(cpu_clk_en_o == 1'b1, "R8 irq wakes idle", cpu_clk_en_o, 1);
    chk(pcon_o == 8'h00, "R8 idle bit cleared", pcon_o, 8'h00);

    // R6, R8: reset and interrupt on the same boundary while idle
    wait_idx(2);
    pcon_write(8'h11);
    wait_idx(0);
    chk(cpu_clk_en_o == 1'b0, "R7 idle entered", cpu_clk_en_o, 0);
    rst_pin_i = 1'b1;
    wait_idx(0);
    chk(cpu_clk_en_o == 1'b0, "R8 still idle after one sample", cpu_clk_en_o, 0);
    wait_idx(2);
    irq_pend_i = 1'b1;
    wait_idx(0);
    irq_pend_i = 1'b0;
    rst_pin_i = 1'b0;
    chk(cpu_clk_en_o && per_clk_en_o, "R8 wake on reset+irq", {cpu_clk_en_o, per_clk_en_o}, 3);
    chk(pcon_o == 8'h10, "R6 keep bit 4", pcon_o, 8'h10);
    chk(int_rst_o == 1'b1, "R4 reset active", int_rst_o, 1);
    wait_idx(10);
    chk(int_rst_o == 1'b0, "R4 reset released", int_rst_o, 0);

    // R9, R11: idle and power-down together
    wait_idx(2);
    pcon_write(8'h13);
    wait_idx(0);
    chk(!cpu_clk_en_o && !per_clk_en_o, "R11 power-down wins", {cpu_clk_en_o, per_clk_en_o}, 0);
    snap = cur_idx();
    sc = state_clk_o;
    irq_pend_i = 1'b1;
    repeat (30) @(negedge clk_i);
    irq_pend_i = 1'b0;
    chk(cur_idx() == snap && state_clk_o == sc, "R9 counter frozen", cur_idx(), snap);
    chk(!cpu_clk_en_o && !per_clk_en_o, "R9 irq ignored", {cpu_clk_en_o, per_clk_en_o}, 0);

    // R10: single-sample pulse refreezes
    rst_pin_i = 1'b1;
    wait_idx(10);
    rst_pin_i = 1'b0;
    repeat (30) @(negedge clk_i);
    snap = cur_idx();
    repeat (12) @(negedge clk_i);
    chk(cur_idx() == snap, "R10 refrozen", cur_idx(), snap);
    chk(!int_rst_o && !per_clk_en_o && !cpu_clk_en_o, "R10 no wake on glitch",
        {int_rst_o, cpu_clk_en_o, per_clk_en_o}, 0);

    // R10: qualified reset wakes
    rst_pin_i = 1'b1;
    for (int k = 0; k < 60 && !int_rst_o; k++) @(negedge clk_i);
    chk(int_rst_o == 1'b1, "R10 reset qualified", int_rst_o, 1);
    wait_idx(0);
    chk(cpu_clk_en_o && per_clk_en_o, "R10 wake by reset", {cpu_clk_en_o, per_clk_en_o}, 3);
    chk(pcon_o == 8'h10, "R6 pcon after power-down reset", pcon_o, 8'h10);
    rst_pin_i = 1'b0;
    wait_idx(10);
    chk(int_rst_o == 1'b0, "R4 release after wake", int_rst_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule